// File: doc/BRIEF.md
# Processor Clock, Ready and Reset Conditioner

This block is the digital front end of a processor clock generator. It runs on a fast master clock and takes two oscillator tick streams: one from an on-board crystal oscillator and one from an external frequency input. Each tick marks one oscillator period. A source select picks one stream. The block divides the chosen stream by three and produces a processor clock that is high for one oscillator period and low for two. When the external source is in use, a sync input can hold the divider so that several generators can be lined up.

The block also conditions two control outputs that are aligned to that clock. Any number of ready requests, each gated by its own active-low enable, are merged and retimed on the rising edges of the processor clock. A mode input selects a one-stage or a two-stage retiming path, and the merged signal forms READY. A low READY makes the processor hold its bus cycle and insert wait states. A raw reset request passes through metastability flops in the master domain. It reaches the RESET output only on a falling edge of the processor clock.

Top module: `cpuclk_rdy_gen`

## Requirements
- R1: The divider has phases 0, 1 and 2, and only phase 0 is high. cpu_clk_o is high for exactly one selected tick period and then low for two, so one period lasts three selected ticks.
- R2: With src_ext_i = 0 the divider advances only on xtal_tick_i, and ext_tick_i has no effect. With src_ext_i = 1 it advances only on ext_tick_i, and xtal_tick_i has no effect.
- R3: With src_ext_i = 1, a selected tick while csync_i = 1 forces phase 2, so cpu_clk_o is low. The first selected tick with csync_i = 0 after that drives cpu_clk_o high. With src_ext_i = 0, csync_i is ignored.
- R4: The qualified ready is the OR over i of rdy_i[i] AND NOT rdy_en_ni[i]. A source whose enable bit is 1 cannot raise ready_o.
- R5: With single_stage_i = 1, ready_o takes the qualified ready that is sampled at the master edge where cpu_clk_o rises. With single_stage_i = 0, ready_o takes the value sampled at the previous rise.
- R6: ready_o changes only on master edges where cpu_clk_o rises.
- R7: reset_o is the inverse of res_req_ni, delayed through two master-clock flops. It is updated only on master edges where cpu_clk_o falls.
- R8: While rst_ni is low: cpu_clk_o = 0, ready_o = 0, reset_o = 1, and the divider sits in phase 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| xtal_tick_i | input | 1 | One-cycle tick per crystal oscillator period |
| ext_tick_i | input | 1 | One-cycle tick per external frequency period |
| src_ext_i | input | 1 | Source select: 0 crystal, 1 external |
| csync_i | input | 1 | Divider hold/align (external source only) |
| rdy_i | input | NUM_RDY | Ready requests |
| rdy_en_ni | input | NUM_RDY | Active-low enable for each ready request |
| single_stage_i | input | 1 | 1 one-stage ready retiming, 0 two-stage |
| res_req_ni | input | 1 | Raw active-low reset request |
| cpu_clk_o | output | 1 | Divide-by-three processor clock, 1/3 duty |
| ready_o | output | 1 | Retimed READY |
| reset_o | output | 1 | Conditioned active-high RESET |

## Verification
The bench goes after four corner cases. The first is ticks that arrive only on the unselected source: a design with a wrong select would move the clock. The second is a sync pulse that lands while the clock is high: a design that parks the divider in the wrong phase would emit an extra high or a short low. The third is a switch between one-stage and two-stage ready retiming: a wrong pipeline would show READY one rise early or late. The fourth is a reset request while ticks are stopped: a design that does not wait for a falling edge would assert RESET with no clock running. Random ticks, sync pulses, enables and mode flips are compared every cycle against a bench model, and directed sequences pin the exact rise and fall cycles.

// File: rtl/cpuclk_rdy_pkg.sv
package cpuclk_rdy_pkg;

   // Counter width for a modulus, never below one bit
   function automatic int unsigned cnt_w(input int unsigned modulus);
      int unsigned w;
      w = $clog2(modulus);
      return (w < 1) ? 1 : w;
   endfunction

   typedef enum logic {
      RDY_TWO_STAGE = 1'b0,
      RDY_ONE_STAGE = 1'b1
   } rdy_mode_e;

endpackage

// File: rtl/cpuclk_div.sv
module cpuclk_div
   import cpuclk_rdy_pkg::*;
#(
   parameter int unsigned DIV_RATIO  = 3,
   parameter int unsigned HIGH_TICKS = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic hold_i,
   output logic cpu_clk_o,
   output logic rise_o,
   output logic fall_o
);

   localparam int unsigned CW = cnt_w(DIV_RATIO);
   localparam logic [CW-1:0] LAST_PH = CW'(DIV_RATIO - 1);
   localparam logic [CW-1:0] HIGH_PH = CW'(HIGH_TICKS);

   if (DIV_RATIO < 2) begin : g_bad_ratio
      $error("cpuclk_div: DIV_RATIO must be at least 2");
   end
   if (HIGH_TICKS < 1 || HIGH_TICKS >= DIV_RATIO) begin : g_bad_high
      $error("cpuclk_div: HIGH_TICKS must lie in 1..DIV_RATIO-1");
   end

   logic [CW-1:0] ph_q, ph_d;
   logic          high_now, high_nxt;

   always_comb begin
      ph_d = ph_q;
      if (tick_i) begin
         if (hold_i) begin
            ph_d = LAST_PH;
         end else if (ph_q == LAST_PH) begin
            ph_d = '0;
         end else begin
            ph_d = ph_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q <= LAST_PH;
      end else begin
         ph_q <= ph_d;
      end
   end

   assign high_now  = (ph_q < HIGH_PH);
   assign high_nxt  = (ph_d < HIGH_PH);
   assign cpu_clk_o = high_now;
   assign rise_o    = !high_now && high_nxt;
   assign fall_o    = high_now && !high_nxt;

endmodule

// File: rtl/cpuclk_rdy_sync.sv
module cpuclk_rdy_sync
   import cpuclk_rdy_pkg::*;
#(
   parameter int unsigned NUM_RDY = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               rise_i,
   input  logic [NUM_RDY-1:0] rdy_i,
   input  logic [NUM_RDY-1:0] en_ni,
   input  logic               one_stage_i,
   output logic               ready_o
);

   if (NUM_RDY < 1) begin : g_bad_num
      $error("cpuclk_rdy_sync: NUM_RDY must be at least 1");
   end

   logic [NUM_RDY-1:0] gated;
   logic               merged;
   logic               stage1_q;
   logic               ready_q;
   rdy_mode_e          mode;

   for (genvar i = 0; i < NUM_RDY; i++) begin : g_qual
      assign gated[i] = rdy_i[i] & ~en_ni[i];
   end

   assign merged = |gated;
   assign mode   = rdy_mode_e'(one_stage_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stage1_q <= 1'b0;
         ready_q  <= 1'b0;
      end else if (rise_i) begin
         stage1_q <= merged;
         ready_q  <= (mode == RDY_ONE_STAGE) ? merged : stage1_q;
      end
   end

   assign ready_o = ready_q;

endmodule

// File: rtl/cpuclk_rst_cond.sv
module cpuclk_rst_cond #(
   parameter int unsigned META_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_ni,
   input  logic fall_i,
   output logic reset_o
);

   if (META_STAGES < 1) begin : g_bad_meta
      $error("cpuclk_rst_cond: META_STAGES must be at least 1");
   end

   logic [META_STAGES-1:0] meta_q;
   logic                   reset_q;

   if (META_STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            meta_q <= '1;
         end else begin
            meta_q <= ~req_ni;
         end
      end
   end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            meta_q <= '1;
         end else begin
            meta_q <= {meta_q[META_STAGES-2:0], ~req_ni};
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         reset_q <= 1'b1;
      end else if (fall_i) begin
         reset_q <= meta_q[META_STAGES-1];
      end
   end

   assign reset_o = reset_q;

endmodule

// File: rtl/cpuclk_rdy_gen.sv
module cpuclk_rdy_gen #(
   parameter int unsigned DIV_RATIO   = 3,
   parameter int unsigned HIGH_TICKS  = 1,
   parameter int unsigned NUM_RDY     = 2,
   parameter int unsigned META_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               xtal_tick_i,
   input  logic               ext_tick_i,
   input  logic               src_ext_i,
   input  logic               csync_i,
   input  logic [NUM_RDY-1:0] rdy_i,
   input  logic [NUM_RDY-1:0] rdy_en_ni,
   input  logic               single_stage_i,
   input  logic               res_req_ni,
   output logic               cpu_clk_o,
   output logic               ready_o,
   output logic               reset_o
);

   logic tick_sel;
   logic hold;
   logic rise;
   logic fall;

   assign tick_sel = src_ext_i ? ext_tick_i : xtal_tick_i;
   assign hold     = src_ext_i & csync_i;

   cpuclk_div #(
      .DIV_RATIO (DIV_RATIO),
      .HIGH_TICKS(HIGH_TICKS)
   ) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_sel),
      .hold_i   (hold),
      .cpu_clk_o(cpu_clk_o),
      .rise_o   (rise),
      .fall_o   (fall)
   );

   cpuclk_rdy_sync #(
      .NUM_RDY(NUM_RDY)
   ) u_rdy (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rise_i     (rise),
      .rdy_i      (rdy_i),
      .en_ni      (rdy_en_ni),
      .one_stage_i(single_stage_i),
      .ready_o    (ready_o)
   );

   cpuclk_rst_cond #(
      .META_STAGES(META_STAGES)
   ) u_rst (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_ni (res_req_ni),
      .fall_i (fall),
      .reset_o(reset_o)
   );

endmodule

// File: rtl/cpuclk_rdy_gen_chk.sv
module cpuclk_rdy_gen_chk #(
   parameter int unsigned DIV_RATIO   = 3,
   parameter int unsigned HIGH_TICKS  = 1,
   parameter int unsigned NUM_RDY     = 2
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               xtal_tick_i,
   input logic               ext_tick_i,
   input logic               src_ext_i,
   input logic               csync_i,
   input logic [NUM_RDY-1:0] rdy_i,
   input logic [NUM_RDY-1:0] rdy_en_ni,
   input logic               single_stage_i,
   input logic               cpu_clk_o,
   input logic               ready_o,
   input logic               reset_o
);

   localparam int LOW_TICKS = int'(DIV_RATIO - HIGH_TICKS);

   logic sel;
   logic held;
   int   hi_seen;
   int   lo_seen;

   assign sel  = src_ext_i ? ext_tick_i : xtal_tick_i;
   assign held = src_ext_i && csync_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_seen <= 0;
         lo_seen <= LOW_TICKS - 1;
      end else begin
         if (!cpu_clk_o)      hi_seen <= 0;
         else if (sel)        hi_seen <= hi_seen + 1;
         if (sel && held)     lo_seen <= LOW_TICKS - 1;
         else if (cpu_clk_o)  lo_seen <= 0;
         else if (sel)        lo_seen <= lo_seen + 1;
      end
   end

   // R1: high phase ends after HIGH_TICKS selected ticks
   a_r1_high_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_clk_o && sel && hi_seen == int'(HIGH_TICKS) - 1) |=> !cpu_clk_o);

   // R1: low phase lasts its full tick count unless sync intervenes
   a_r1_low_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cpu_clk_o && sel && !held && lo_seen < LOW_TICKS - 1) |=> !cpu_clk_o);

   // R2: no selected tick, no clock movement
   a_r2_idle_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel |=> $stable(cpu_clk_o));

   // R3: sync on the external source holds the clock low
   a_r3_sync_holds_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel && held) |=> !cpu_clk_o);

   // R4: all sources disabled gives no ready in one-stage mode
   a_r4_disabled_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(cpu_clk_o) && $past(single_stage_i) && ($past(rdy_en_ni) == '1)) |-> !ready_o);

   // R5: one-stage mode samples at the rising edge
   a_r5_single_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(cpu_clk_o) && $past(single_stage_i)) |-> (ready_o == $past(|(rdy_i & ~rdy_en_ni))));

   // R6: ready moves only with a rising processor clock
   a_r6_ready_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$rose(cpu_clk_o) |-> $stable(ready_o));

   // R7: reset output moves only with a falling processor clock
   a_r7_reset_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$fell(cpu_clk_o) |-> $stable(reset_o));

endmodule

bind cpuclk_rdy_gen cpuclk_rdy_gen_chk #(
   .DIV_RATIO (DIV_RATIO),
   .HIGH_TICKS(HIGH_TICKS),
   .NUM_RDY   (NUM_RDY)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .xtal_tick_i   (xtal_tick_i),
   .ext_tick_i    (ext_tick_i),
   .src_ext_i     (src_ext_i),
   .csync_i       (csync_i),
   .rdy_i         (rdy_i),
   .rdy_en_ni     (rdy_en_ni),
   .single_stage_i(single_stage_i),
   .cpu_clk_o     (cpu_clk_o),
   .ready_o       (ready_o),
   .reset_o       (reset_o)
);

// File: tb/tb_cpuclk_rdy_gen.sv
`timescale 1ns/1ps
module tb_cpuclk_rdy_gen;

   localparam int DIV  = 3;
   localparam int HIGH = 1;
   localparam int NR   = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          xtal_tick = 1'b0;
   logic          ext_tick = 1'b0;
   logic          src_ext = 1'b0;
   logic          csync = 1'b0;
   logic [NR-1:0] rdy = '0;
   logic [NR-1:0] en_n = '1;
   logic          single = 1'b1;
   logic          res_req_n = 1'b1;
   logic          cpu_clk, ready, reset_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cpuclk_rdy_gen #(
      .DIV_RATIO(DIV), .HIGH_TICKS(HIGH), .NUM_RDY(NR), .META_STAGES(2)
   ) dut (
      .clk_i(clk), .rst_ni(rst_n), .xtal_tick_i(xtal_tick), .ext_tick_i(ext_tick),
      .src_ext_i(src_ext), .csync_i(csync), .rdy_i(rdy), .rdy_en_ni(en_n),
      .single_stage_i(single), .res_req_ni(res_req_n),
      .cpu_clk_o(cpu_clk), .ready_o(ready), .reset_o(reset_out)
   );

   // ---------------- bench model ----------------
   function automatic bit qual_fn(input logic [NR-1:0] r, input logic [NR-1:0] e);
      bit q = 1'b0;
      for (int i = 0; i < NR; i++) q = q | (r[i] & ~e[i]);
      return q;
   endfunction

   function automatic int next_phase(input int ph, input bit tick, input bit hold);
      if (!tick) return ph;
      if (hold) return DIV - 1;
      return (ph + 1) % DIV;
   endfunction

   int   m_ph = DIV - 1;
   bit   m_s1 = 1'b0;
   bit   m_rdy = 1'b0;
   bit   m_rst = 1'b1;
   bit [1:0] m_sh = 2'b11;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = DIV - 1; m_s1 = 1'b0; m_rdy = 1'b0; m_rst = 1'b1; m_sh = 2'b11;
      end else begin
         int  nph;
         bit  was_hi, now_hi, q;
         nph    = next_phase(m_ph, src_ext ? ext_tick : xtal_tick, src_ext && csync);
         was_hi = (m_ph < HIGH);
         now_hi = (nph < HIGH);
         q      = qual_fn(rdy, en_n);
         if (!was_hi && now_hi) begin
            m_rdy = single ? q : m_s1;
            m_s1  = q;
         end
         if (was_hi && !now_hi) m_rst = m_sh[1];
         m_sh = {m_sh[0], ~res_req_n};
         m_ph = nph;
      end
   end

   task automatic check(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         check("R1 cpu_clk", cpu_clk, (m_ph < HIGH));
         check("R5 R6 ready", ready, m_rdy);
         check("R7 reset", reset_out, m_rst);
      end
   end

   task automatic wait_rise();
      logic last;
      last = cpu_clk;
      forever begin
         @(negedge clk);
         if (cpu_clk && !last) break;
         last = cpu_clk;
      end
   endtask

   task automatic rand_phase(input int cycles, input bit src, input int sync_pct,
                             input int res_pct, input int mode_pct);
      src_ext = src;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         xtal_tick = 1'($urandom_range(0, 1));
         ext_tick  = ($urandom_range(0, 2) == 0);
         csync     = ($urandom_range(0, 99) < sync_pct);
         rdy       = NR'($urandom_range(0, (1 << NR) - 1));
         en_n      = NR'($urandom_range(0, (1 << NR) - 1));
         if ($urandom_range(0, 99) < mode_pct) single = ~single;
         if ($urandom_range(0, 99) < res_pct) res_req_n = ~res_req_n;
      end
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit moved;
      logic lvl;
      void'($urandom(32'd20240611));

      // R8: reset state
      repeat (4) @(negedge clk);
      check("R8 cpu_clk in reset", cpu_clk, 1'b0);
      check("R8 ready in reset", ready, 1'b0);
      check("R8 reset_o in reset", reset_out, 1'b1);
      rst_n = 1'b1;

      // R2: only the unselected source ticks
      @(negedge clk);
      src_ext = 1'b0; xtal_tick = 1'b0; ext_tick = 1'b1;
      @(negedge clk);
      lvl = cpu_clk; moved = 1'b0;
      repeat (12) begin @(negedge clk); if (cpu_clk !== lvl) moved = 1'b1; end
      check("R2 ext ticks ignored on crystal", moved, 1'b0);
      src_ext = 1'b1; xtal_tick = 1'b1; ext_tick = 1'b0;
      @(negedge clk);
      lvl = cpu_clk; moved = 1'b0;
      repeat (12) begin @(negedge clk); if (cpu_clk !== lvl) moved = 1'b1; end
      check("R2 crystal ticks ignored on external", moved, 1'b0);

      // R7: reset released on a fall after sync delay
      xtal_tick = 1'b0; ext_tick = 1'b1;
      repeat (12) @(negedge clk);
      check("R7 reset released", reset_out, 1'b0);

      // R3: sync hold then release, R1 exact pattern
      csync = 1'b1;
      repeat (10) @(negedge clk);
      check("R3 held low by sync", cpu_clk, 1'b0);
      csync = 1'b0;
      @(negedge clk); check("R3 high on first tick after sync", cpu_clk, 1'b1);
      @(negedge clk); check("R1 low phase 1", cpu_clk, 1'b0);
      @(negedge clk); check("R1 low phase 2", cpu_clk, 1'b0);
      @(negedge clk); check("R1 high again", cpu_clk, 1'b1);

      // R3: sync ignored on crystal source
      src_ext = 1'b0; xtal_tick = 1'b1; csync = 1'b1; moved = 1'b0;
      repeat (6) begin @(negedge clk); if (cpu_clk) moved = 1'b1; end
      check("R3 sync ignored on crystal", moved, 1'b1);
      csync = 1'b0;

      // R4: disabled sources cannot raise ready
      single = 1'b1; rdy = '1; en_n = '1;
      wait_rise(); wait_rise();
      check("R4 all disabled", ready, 1'b0);
      en_n = 2'b01;
      wait_rise();
      check("R4 source 1 enabled", ready, 1'b1);
      rdy = 2'b10; en_n = 2'b10;
      wait_rise();
      check("R4 source 1 disabled source 0 low", ready, 1'b0);

      // R5: two-stage latency
      single = 1'b0; rdy = '0; en_n = '0;
      wait_rise(); wait_rise();
      rdy = 2'b01;
      wait_rise();
      check("R5 two-stage first rise", ready, 1'b0);
      wait_rise();
      check("R5 two-stage second rise", ready, 1'b1);

      // R7: request with stopped ticks waits for a fall
      xtal_tick = 1'b0; res_req_n = 1'b0;
      repeat (10) @(negedge clk);
      check("R7 no fall no reset", reset_out, 1'b0);
      xtal_tick = 1'b1;
      repeat (6) @(negedge clk);
      check("R7 reset after fall", reset_out, 1'b1);
      res_req_n = 1'b1;

      // random phases
      rand_phase(3000, 1'b0, 5, 1, 2);
      rand_phase(3000, 1'b1, 5, 1, 2);
      rand_phase(2000, 1'b1, 30, 2, 5);

      // R8: reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R8 mid-run cpu_clk", cpu_clk, 1'b0);
      check("R8 mid-run ready", ready, 1'b0);
      check("R8 mid-run reset_o", reset_out, 1'b1);
      rst_n = 1'b1;
      rand_phase(3000, 1'b0, 10, 1, 3);

      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule